// File: doc/BRIEF.md
# Cache flush sequencer

This block empties a small cache state array when an external flush request is raised. The request arrives with no timing relation to the core clock, so it is first brought into the clock domain. A rising request then starts a walk over every line index, lowest first. A line found dirty is handed to a write-back port and the walk waits for that port to answer. Only after that is the line cleared. Lines that are not dirty are cleared in one cycle each. When the last line has been handled, the block raises a flush-acknowledge pulse for one cycle.

For as long as the synchronized request stays high, and for the whole walk, the block refuses line fills. This keeps the array empty until the requester lets go. A held request starts only one walk, and a new walk needs a fresh rising edge. The same input also works as a configuration strap: its level at the moment reset is released is stored in a bit that holds until the next reset, and that level never starts a walk by itself.

Top module: `flush_seq`

## Requirements
- R1: The flush input passes through a two-stage synchronizer. After it rises, `alloc_lock` is still low one clock edge later and is high two clock edges later.
- R2: `strap_cfg` holds the flush input's level at the last cycle of reset. It keeps that value until reset is asserted again. A level that is high when reset is released starts no walk and produces no write-back and no acknowledge.
- R3: A walk visits line indexes 0 to LINES-1 in ascending order. Each line in state 2'b11 (modified) raises `wb_req` with `wb_idx` equal to its index. `wb_req` and `wb_idx` stay steady until `wb_ack` is seen. The number of write-backs equals the number of modified lines, and no other state causes one.
- R4: Line states are encoded 2'b00 invalid, 2'b01 shared, 2'b10 exclusive and 2'b11 modified. After a walk every line reads back 2'b00 on `rd_state`.
- R5: Each walk ends with exactly one `flush_ack` pulse, one cycle wide. When no line is modified, the pulse is high after the 19th clock edge counted from the rising request, for the default 16 lines.
- R6: A fill is taken (`fill_accept` high and the line written) only when `alloc_lock` is low. `alloc_lock` is high while the synchronized request is high or a walk runs, including after the walk has finished. A refused fill leaves the line unchanged.
- R7: A request held high starts only one walk. A rising edge of the request after the acknowledge starts a new walk.
- R8: After reset every line reads invalid, and `flush_ack`, `wb_req` and `alloc_lock` are low while the flush input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_in | input | 1 | Asynchronous flush request; also sampled as the strap at reset release |
| strap_cfg | output | 1 | Configuration bit captured at reset release |
| alloc_lock | output | 1 | High while fills are refused |
| fill_valid | input | 1 | Fill request for one line |
| fill_idx | input | IDX_W | Line index of the fill |
| fill_state | input | 2 | State written by the fill |
| fill_accept | output | 1 | Fill taken this cycle |
| rd_idx | input | IDX_W | Line index to observe |
| rd_state | output | 2 | State of line `rd_idx` |
| wb_req | output | 1 | Write-back request for a modified line |
| wb_idx | output | IDX_W | Index of the line being written back |
| wb_ack | input | 1 | Write-back complete |
| flush_ack | output | 1 | One-cycle flush-acknowledge pulse |

## Verification
The lock rises two edges after the flush input, and the bench samples it at the falling edges after the first and the second edge. A walk over clean lines starts on the third edge and uses one edge per line, so the acknowledge is sampled low after edge 18, high after edge 19 and low again after edge 20. When lines are modified, the delay depends on the write-back responder. For those walks the bench waits for the acknowledge count to change, bounded by a timeout, and then checks the write-back log, the final line states and the acknowledge count. Fill results are sampled one time step after the fill is driven, and the array is read back one cycle later.

// File: rtl/flush_pkg.sv
// Shared types for the cache flush sequencer.
package flush_pkg;
    // Per-line coherence state; the encoding is visible at rd_state.
    typedef enum logic [1:0] {
        LN_INV = 2'b00,
        LN_SHR = 2'b01,
        LN_EXC = 2'b10,
        LN_MOD = 2'b11
    } line_st_e;

    // Walk controller states.
    typedef enum logic [1:0] {
        WK_IDLE,
        WK_SCAN,
        WK_WBWAIT,
        WK_DONE
    } walk_st_e;
endpackage

// File: rtl/flush_req_sync.sv
// Brings the asynchronous flush input into the clock domain and captures
// its level as a configuration strap while reset is asserted.
// Assumes STAGES >= 2. The synchronizer chain is deliberately left
// unreset, so it carries the live input level up to the release of reset.
module flush_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    output logic req_sync,
    output logic strap
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw input through the synchronizer flops.
    always_ff @(posedge clk) begin
        chain_q <= {chain_q[STAGES-2:0], req_async};
    end

    assign req_sync = chain_q[STAGES-1];

    // Follow the synchronized level during reset; freeze it once released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap <= chain_q[STAGES-1];
        end
    end
endmodule

// File: rtl/line_state_array.sv
// Behavioural per-line state store. It has one fill write port, one
// invalidate port, and two combinational read ports (observe and scan).
// Assumes the owner never fills while invalidating; invalidate wins anyway.
module line_state_array
    import flush_pkg::*;
#(
    parameter int LINES = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_st_e         wr_st,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic [IDX_W-1:0] rd_a_idx,
    output line_st_e         rd_a_st,
    input  logic [IDX_W-1:0] rd_b_idx,
    output line_st_e         rd_b_st
);
    line_st_e st_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // One state register per line: clear on reset or invalidate, else fill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g] <= LN_INV;
            end else if (inv_en && inv_idx == IDX_W'(g)) begin
                st_q[g] <= LN_INV;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                st_q[g] <= wr_st;
            end
        end
    end

    assign rd_a_st = st_q[rd_a_idx];
    assign rd_b_st = st_q[rd_b_idx];
endmodule

// File: rtl/flush_walker.sv
// Walk controller. On a rising synchronized request it visits every line
// in ascending order. A modified line is handed to the write-back port and
// cleared after the acknowledge; any other line is cleared at once. A
// one-cycle flush acknowledge ends the walk.
// Assumes wb_ack is only asserted while wb_req is high.
module flush_walker
    import flush_pkg::*;
#(
    parameter int LINES = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_sync,
    input  line_st_e         scan_st,
    output logic [IDX_W-1:0] scan_idx,
    output logic             inv_en,
    output logic             wb_req,
    output logic [IDX_W-1:0] wb_idx,
    input  logic             wb_ack,
    output logic             flush_ack,
    output logic             busy
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

    walk_st_e         st_q;
    logic [IDX_W-1:0] idx_q;
    logic             req_prev_q;
    logic             wb_req_q;
    logic             start;
    logic             last;

    // Previous request level; it tracks through reset so a level held at release is no edge.
    always_ff @(posedge clk) begin
        req_prev_q <= req_sync;
    end

    assign start = req_sync && !req_prev_q && (st_q == WK_IDLE);
    assign last  = (idx_q == LAST_IDX);

    // Walk state machine: scan, wait for write-back, acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= WK_IDLE;
            idx_q    <= '0;
            wb_req_q <= 1'b0;
        end else begin
            case (st_q)
                WK_IDLE: begin
                    if (start) begin
                        st_q  <= WK_SCAN;
                        idx_q <= '0;
                    end
                end
                WK_SCAN: begin
                    if (scan_st == LN_MOD) begin
                        wb_req_q <= 1'b1;
                        st_q     <= WK_WBWAIT;
                    end else if (last) begin
                        st_q <= WK_DONE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                WK_WBWAIT: begin
                    if (wb_ack) begin
                        wb_req_q <= 1'b0;
                        if (last) begin
                            st_q <= WK_DONE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            st_q  <= WK_SCAN;
                        end
                    end
                end
                default: begin
                    st_q <= WK_IDLE;
                end
            endcase
        end
    end

    // Clear a clean line while scanning it, or a dirty line once its write-back completes.
    always_comb begin
        inv_en = ((st_q == WK_SCAN) && (scan_st != LN_MOD)) ||
                 ((st_q == WK_WBWAIT) && wb_ack);
    end

    assign scan_idx  = idx_q;
    assign wb_idx    = idx_q;
    assign wb_req    = wb_req_q;
    assign flush_ack = (st_q == WK_DONE);
    assign busy      = (st_q != WK_IDLE);
endmodule

// File: rtl/flush_seq.sv
// Cache flush sequencer top. It ties together the request synchronizer,
// the line state array and the walk controller, and applies the fill
// lockout. Assumes fills come from a single requester.
module flush_seq #(
    parameter int LINES       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_in,
    output logic             strap_cfg,
    output logic             alloc_lock,
    input  logic             fill_valid,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [1:0]       fill_state,
    output logic             fill_accept,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_state,
    output logic             wb_req,
    output logic [IDX_W-1:0] wb_idx,
    input  logic             wb_ack,
    output logic             flush_ack
);
    import flush_pkg::*;

    logic             req_sync;
    logic             walk_busy;
    logic             inv_en;
    logic [IDX_W-1:0] scan_idx;
    line_st_e         scan_st;
    line_st_e         obs_st;

    flush_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_async(flush_in),
        .req_sync (req_sync),
        .strap    (strap_cfg)
    );

    // Fills are refused while the request is held or a walk is in progress.
    always_comb begin
        alloc_lock  = req_sync || walk_busy;
        fill_accept = fill_valid && !alloc_lock;
    end

    line_state_array #(.LINES(LINES), .IDX_W(IDX_W)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fill_accept),
        .wr_idx  (fill_idx),
        .wr_st   (line_st_e'(fill_state)),
        .inv_en  (inv_en),
        .inv_idx (scan_idx),
        .rd_a_idx(rd_idx),
        .rd_a_st (obs_st),
        .rd_b_idx(scan_idx),
        .rd_b_st (scan_st)
    );

    assign rd_state = obs_st;

    flush_walker #(.LINES(LINES), .IDX_W(IDX_W)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_sync (req_sync),
        .scan_st  (scan_st),
        .scan_idx (scan_idx),
        .inv_en   (inv_en),
        .wb_req   (wb_req),
        .wb_idx   (wb_idx),
        .wb_ack   (wb_ack),
        .flush_ack(flush_ack),
        .busy     (walk_busy)
    );
endmodule

// File: rtl/flush_seq_chk.sv
// Temporal checks for flush_seq, attached by bind. It only observes.
module flush_seq_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wb_req,
    input logic             wb_ack,
    input logic [IDX_W-1:0] wb_idx,
    input logic             flush_ack,
    input logic             fill_accept,
    input logic             walk_busy,
    input logic [1:0]       scan_st,
    input logic             strap
);
    // R3: an unanswered write-back keeps its request and index.
    p_wb_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_idx)));

    // R3: only a line stored as modified is ever written back.
    p_wb_mod_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (scan_st == 2'b11));

    // R5: the acknowledge is a single-cycle pulse.
    p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ack |=> !flush_ack);

    // R5: the walk is over right after the acknowledge.
    p_ack_ends_walk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ack |=> !walk_busy);

    // R6: no fill is taken during a walk.
    p_no_fill_walk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        walk_busy |-> !fill_accept);

    // R2: the strap stays constant outside reset.
    p_strap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap));
endmodule

bind flush_seq flush_seq_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wb_req     (wb_req),
    .wb_ack     (wb_ack),
    .wb_idx     (wb_idx),
    .flush_ack  (flush_ack),
    .fill_accept(fill_accept),
    .walk_busy  (walk_busy),
    .scan_st    (scan_st),
    .strap      (strap_cfg)
);

// File: tb/flush_seq_test.sv
// Directed bench for flush_seq: one task per scenario.
module flush_seq_test;
    localparam int CLK_P  = 10;
    localparam int LINES  = 16;
    localparam int IDX_W  = $clog2(LINES);
    localparam int WB_DLY = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flush_in = 1'b0;
    logic             strap_cfg;
    logic             alloc_lock;
    logic             fill_valid = 1'b0;
    logic [IDX_W-1:0] fill_idx = '0;
    logic [1:0]       fill_state = 2'b00;
    logic             fill_accept;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [1:0]       rd_state;
    logic             wb_req;
    logic [IDX_W-1:0] wb_idx;
    logic             wb_ack = 1'b0;
    logic             flush_ack;

    int n_chk = 0;
    int n_bad = 0;
    int ack_cnt = 0;
    int wb_cnt = 0;
    int dly = 0;
    int wb_log [64];
    bit done = 1'b0;

    flush_seq #(.LINES(LINES)) uut (
        .clk(clk), .rst_n(rst_n), .flush_in(flush_in), .strap_cfg(strap_cfg),
        .alloc_lock(alloc_lock), .fill_valid(fill_valid), .fill_idx(fill_idx),
        .fill_state(fill_state), .fill_accept(fill_accept), .rd_idx(rd_idx),
        .rd_state(rd_state), .wb_req(wb_req), .wb_idx(wb_idx), .wb_ack(wb_ack),
        .flush_ack(flush_ack)
    );

    always #(CLK_P/2) clk = ~clk;

    // Write-back responder and acknowledge counter, both on the falling edge.
    always @(negedge clk) begin
        if (rst_n && flush_ack) ack_cnt++;
        if (rst_n && wb_req && !wb_ack) begin
            if (dly == WB_DLY) begin
                wb_ack <= 1'b1;
                if (wb_cnt < 64) wb_log[wb_cnt] = int'(wb_idx);
                wb_cnt++;
                dly = 0;
            end else begin
                dly++;
            end
        end else begin
            wb_ack <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic do_reset(input logic lvl);
        @(negedge clk);
        rst_n = 1'b0;
        flush_in = lvl;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic read_line(input int idx, output logic [1:0] st);
        rd_idx = IDX_W'(idx);
        #1;
        st = rd_state;
    endtask

    task automatic do_fill(input int idx, input logic [1:0] st, input logic exp_acc, input string rq);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_idx = IDX_W'(idx);
        fill_state = st;
        #1;
        check(fill_accept == exp_acc, rq, fill_accept, exp_acc);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic check_all_invalid(input string rq);
        logic [1:0] st;
        int nonzero = 0;
        for (int i = 0; i < LINES; i++) begin
            read_line(i, st);
            if (st != 2'b00) nonzero++;
        end
        check(nonzero == 0, rq, nonzero, 0);
    endtask

    task automatic wait_ack(input int base);
        int t = 0;
        while (ack_cnt == base && t < 2000) begin
            @(negedge clk);
            t++;
        end
    endtask

    // R8: state after a plain reset.
    task automatic t_reset_state();
        do_reset(1'b0);
        @(negedge clk);
        check(strap_cfg == 1'b0, "R2 strap low", strap_cfg, 0);
        check(!alloc_lock && !wb_req && !flush_ack, "R8 outputs idle",
              int'({alloc_lock, wb_req, flush_ack}), 0);
        check_all_invalid("R8 lines invalid after reset");
    endtask

    // R2: high level at reset release is a strap and not a flush.
    task automatic t_strap();
        int a0;
        do_reset(1'b1);
        a0 = ack_cnt;
        @(negedge clk);
        check(strap_cfg == 1'b1, "R2 strap captured high", strap_cfg, 1);
        repeat (40) @(negedge clk);
        check(ack_cnt == a0, "R2 no ack from strap level", ack_cnt, a0);
        check(wb_cnt == 0, "R2 no write-back from strap level", wb_cnt, 0);
        flush_in = 1'b0;
        repeat (3) @(negedge clk);
        check(strap_cfg == 1'b1, "R2 strap held after input drops", strap_cfg, 1);
        do_reset(1'b0);
        @(negedge clk);
        check(strap_cfg == 1'b0, "R2 strap recaptured low", strap_cfg, 0);
    endtask

    // R3 R4 R5: mixed states, one line of each kind per group of four.
    task automatic t_mixed_walk();
        int a0;
        int w0;
        for (int i = 0; i < LINES; i++) do_fill(i, 2'(i % 4), 1'b1, "R6 fill accepted when idle");
        a0 = ack_cnt;
        w0 = wb_cnt;
        @(negedge clk);
        flush_in = 1'b1;
        @(negedge clk);
        check(alloc_lock == 1'b0, "R1 lock low after one edge", alloc_lock, 0);
        @(negedge clk);
        check(alloc_lock == 1'b1, "R1 lock high after two edges", alloc_lock, 1);
        wait_ack(a0);
        repeat (2) @(negedge clk);
        check(wb_cnt - w0 == 4, "R3 write-back count equals modified lines", wb_cnt - w0, 4);
        for (int k = 0; k < 4; k++)
            check(wb_log[w0 + k] == 3 + 4 * k, "R3 write-back index order", wb_log[w0 + k], 3 + 4 * k);
        check_all_invalid("R4 all lines invalid after walk");
        check(ack_cnt - a0 == 1, "R5 one acknowledge", ack_cnt - a0, 1);
    endtask

    // R6 R7: request still held after the walk.
    task automatic t_lockout();
        logic [1:0] st;
        int a0 = ack_cnt;
        repeat (30) @(negedge clk);
        check(ack_cnt == a0, "R7 held request gives no second walk", ack_cnt, a0);
        check(alloc_lock == 1'b1, "R6 lock held with request", alloc_lock, 1);
        do_fill(2, 2'b11, 1'b0, "R6 fill refused while held");
        read_line(2, st);
        check(st == 2'b00, "R6 refused fill leaves line", st, 0);
        flush_in = 1'b0;
        repeat (3) @(negedge clk);
        check(alloc_lock == 1'b0, "R6 lock released", alloc_lock, 0);
        do_fill(2, 2'b11, 1'b1, "R6 fill accepted after release");
        read_line(2, st);
        check(st == 2'b11, "R6 accepted fill stored", st, 3);
    endtask

    // R7 R3: a new rising edge starts a second walk; even lines dirty.
    task automatic t_rerise();
        int a0;
        int w0;
        for (int i = 0; i < LINES; i++)
            if (i != 2) do_fill(i, (i % 2 == 0) ? 2'b11 : 2'b10, 1'b1, "R6 fill accepted when idle");
        a0 = ack_cnt;
        w0 = wb_cnt;
        @(negedge clk);
        flush_in = 1'b1;
        wait_ack(a0);
        repeat (2) @(negedge clk);
        check(ack_cnt - a0 == 1, "R7 re-rise starts a walk", ack_cnt - a0, 1);
        check(wb_cnt - w0 == 8, "R3 write-backs for even lines", wb_cnt - w0, 8);
        check_all_invalid("R4 all invalid after second walk");
        flush_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // R5: acknowledge timing over clean lines only.
    task automatic t_clean_timing();
        for (int i = 0; i < LINES; i++) do_fill(i, (i % 2 == 0) ? 2'b01 : 2'b10, 1'b1, "R6 fill accepted when idle");
        @(negedge clk);
        flush_in = 1'b1;
        repeat (18) @(negedge clk);
        check(flush_ack == 1'b0, "R5 ack not before edge 19", flush_ack, 0);
        @(negedge clk);
        check(flush_ack == 1'b1, "R5 ack after edge 19", flush_ack, 1);
        @(negedge clk);
        check(flush_ack == 1'b0, "R5 ack one cycle wide", flush_ack, 0);
        check_all_invalid("R4 clean lines invalid");
        flush_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        t_reset_state();
        t_strap();
        t_mixed_walk();
        t_lockout();
        t_rerise();
        t_clean_timing();
        check(wb_cnt == 12, "R3 total write-backs", wb_cnt, 12);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule